// File: doc/BRIEF.md
# Interrupt Translation Command Queue Engine

The engine walks a circular queue of 32-byte command packets kept in memory. Software programs the queue's base address and its size, then writes a write offset. While the engine is enabled it reads packets one at a time, starting at its read offset. It hands each complete packet to a command handler and waits for that handler's verdict before it moves on. The table walks and the state updates that a command triggers belong to the handlers, not to this block.

Each packet is fetched as four 64-bit doublewords, with one read outstanding at a time. A continue verdict moves the read offset forward by one packet, and the offset wraps to zero at the end of the queue. A memory fault stops the queue, and so does a stall verdict; for a bad parameter, the handler returns continue, so the command is simply skipped. A stopped queue stays stopped until the base register is written again or the block is reset. Turning the enable off and on again keeps the read offset, so processing picks up where it left off.

Back-pressure rules: a read request holds its valid and address until it is accepted. Read data is taken only while the engine asserts its response ready. A dispatched packet holds its valid and contents until the handler accepts it. A verdict is taken only while the engine asserts its verdict ready. A base register write is the one exception: it abandons the command in flight, withdraws any pending request or dispatch, and quietly drains any response or verdict that is still owed.

Top module: `cmdq_engine`

## Requirements
- R1: A command is read as four doubleword reads at base + read offset + 8·k, for k = 0, 1, 2, 3 in that order, with one read outstanding at a time. The packet is dispatched only after all four reads, as {dw3, dw2, dw1, dw0}, and the opcode output is bits 7:0 of dw0.
- R2: If the read of dw0 returns an error, the opcode is not decoded and nothing is dispatched. No further reads are issued, the stalled flag rises, and the read offset does not change.
- R3: If the read of dw1, dw2 or dw3 returns an error, nothing is dispatched, no further reads are issued, the stalled flag rises, and the read offset does not change.
- R4: A continue verdict (stall bit 0) advances the read offset by 32.
- R5: A stall verdict (stall bit 1) raises the stalled flag and leaves the read offset unchanged. While stalled, the engine issues no reads and no dispatches.
- R6: The queue is (size field + 1) · PAGE_BYTES bytes long. When the read offset plus 32 reaches that length, the offset wraps to 0.
- R7: A base register write sets the read offset to 0 and clears the stalled flag. It leaves the write offset unchanged.
- R8: A command starts only while the engine is enabled, not stalled, and the read offset differs from the write offset. Clearing the enable and setting it again keeps the read offset.
- R9: Only one command is in flight: no read is issued between a dispatch and the verdict for it.
- R10: A read request and a dispatch each hold valid and payload stable until they are accepted, unless a base register write intervenes.
- R11: A write-offset write stores the value with its low five bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Queue processing enable |
| base_we | input | 1 | Base register write strobe |
| base_addr | input | ADDR_W | Queue base address |
| base_pages | input | SIZE_W | Queue size in pages, minus one |
| wptr_we | input | 1 | Write-offset write strobe |
| wptr_wdata | input | OFF_W | New write offset |
| wptr | output | OFF_W | Current write offset |
| rptr | output | OFF_W | Current read offset |
| stalled | output | 1 | Queue stopped on a fault or a stall verdict |
| mrd_req_valid | output | 1 | Doubleword read request valid |
| mrd_req_ready | input | 1 | Read request accepted |
| mrd_req_addr | output | ADDR_W | Doubleword read address |
| mrd_rsp_valid | input | 1 | Read data valid |
| mrd_rsp_ready | output | 1 | Engine takes read data |
| mrd_rsp_data | input | 64 | Read data |
| mrd_rsp_err | input | 1 | Read fault |
| dsp_valid | output | 1 | Packet offered to handlers |
| dsp_ready | input | 1 | Handler accepts packet |
| dsp_opcode | output | 8 | Command opcode |
| dsp_pkt | output | 256 | Whole packet {dw3,dw2,dw1,dw0} |
| vrd_valid | input | 1 | Handler verdict valid |
| vrd_ready | output | 1 | Engine takes verdict |
| vrd_stall | input | 1 | 1 = stall queue, 0 = continue |

## Verification
The bench faults the first doubleword and, separately, the third doubleword. A design that decoded a faulted opcode would dispatch a packet that nobody expected. A design that treated faults as skips would move its read offset forward and keep reading. The queue is driven across its end, so an engine that wrapped at the wrong length would read an address outside the queue. The bench also clears the enable with work pending, then writes the base register while the queue is stalled. An engine that reset its offset on enable, or cleared the write offset on a base write, would reread old packets or sit idle.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int PKT_DW    = 4;
  localparam int DW_W      = 64;
  localparam int DW_BYTES  = 8;
  localparam int PKT_BYTES = PKT_DW * DW_BYTES;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_RSP,
    S_DISP,
    S_VRD,
    S_DRN_RSP,
    S_DRN_VRD
  } seq_state_e;
endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 8,
  parameter int PG_W   = 12,
  localparam int OFF_W = PG_W + SIZE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [SIZE_W-1:0] base_pages,
  input  logic              wptr_we,
  input  logic [OFF_W-1:0]  wptr_wdata,
  input  logic              adv,
  input  logic              stall_set,
  output logic [ADDR_W-1:0] base_q,
  output logic [OFF_W-1:0]  wptr_q,
  output logic [OFF_W-1:0]  rptr_q,
  output logic              stalled_q
);
  localparam int QS_W = OFF_W + 1;
  localparam logic [OFF_W-1:0] ALIGN_MASK = ~OFF_W'(PKT_BYTES - 1);

  logic [SIZE_W-1:0] pages_q;
  logic [QS_W-1:0]   qsize;
  logic [QS_W-1:0]   rsum;
  logic [OFF_W-1:0]  rptr_nxt;

  // queue length in bytes and the wrapped next read offset
  always_comb begin
    qsize    = (QS_W'(pages_q) + QS_W'(1)) << PG_W;
    rsum     = QS_W'(rptr_q) + QS_W'(PKT_BYTES);
    rptr_nxt = (rsum >= qsize) ? '0 : rsum[OFF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      pages_q   <= '0;
      rptr_q    <= '0;
      stalled_q <= 1'b0;
    end else if (base_we) begin
      base_q    <= base_addr;
      pages_q   <= base_pages;
      rptr_q    <= '0;
      stalled_q <= 1'b0;
    end else begin
      if (adv)       rptr_q    <= rptr_nxt;
      if (stall_set) stalled_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       wptr_q <= '0;
    else if (wptr_we) wptr_q <= wptr_wdata & ALIGN_MASK;
  end
endmodule

// File: rtl/cmdq_pktbuf.sv
module cmdq_pktbuf
  import cmdq_pkg::*;
#(
  localparam int IDX_W = $clog2(PKT_DW),
  localparam int PKT_W = PKT_DW * DW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW_W-1:0]  wr_data,
  output logic [PKT_W-1:0] pkt
);
  for (genvar g = 0; g < PKT_DW; g++) begin : g_dw
    logic [DW_W-1:0] dw_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                               dw_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))    dw_q <= wr_data;
    end
    assign pkt[g*DW_W +: DW_W] = dw_q;
  end
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 20,
  localparam int IDX_W = $clog2(PKT_DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [OFF_W-1:0]  rptr,
  input  logic [OFF_W-1:0]  wptr,
  input  logic              stalled,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_err,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_idx,
  output logic              dsp_valid,
  input  logic              dsp_ready,
  input  logic              vrd_valid,
  output logic              vrd_ready,
  input  logic              vrd_stall,
  output logic              adv,
  output logic              stall_set,
  output logic              live
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic             go;
  logic             last_dw;

  assign go      = en && !stalled && (rptr != wptr) && !base_we;
  assign last_dw = (idx_q == IDX_W'(PKT_DW - 1));

  assign req_valid = (state_q == S_REQ);
  assign req_addr  = base_q + ADDR_W'(rptr) + ADDR_W'({idx_q, 3'b000});
  assign rsp_ready = (state_q == S_RSP) || (state_q == S_DRN_RSP);
  assign dsp_valid = (state_q == S_DISP);
  assign vrd_ready = (state_q == S_VRD) || (state_q == S_DRN_VRD);
  assign live      = (state_q != S_DRN_RSP) && (state_q != S_DRN_VRD);

  assign buf_we  = (state_q == S_RSP) && rsp_valid && !rsp_err;
  assign buf_idx = idx_q;

  assign adv       = (state_q == S_VRD) && vrd_valid && !vrd_stall && !base_we;
  assign stall_set = !base_we &&
                     (((state_q == S_VRD) && vrd_valid && vrd_stall) ||
                      ((state_q == S_RSP) && rsp_valid && rsp_err));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (go) state_d = S_REQ;
      S_REQ: begin
        if (base_we)        state_d = req_ready ? S_DRN_RSP : S_IDLE;
        else if (req_ready) state_d = S_RSP;
      end
      S_RSP: begin
        if (rsp_valid) begin
          if (base_we || rsp_err) state_d = S_IDLE;
          else if (last_dw)       state_d = S_DISP;
          else                    state_d = S_REQ;
        end else if (base_we) begin
          state_d = S_DRN_RSP;
        end
      end
      S_DISP: begin
        if (base_we)        state_d = dsp_ready ? S_DRN_VRD : S_IDLE;
        else if (dsp_ready) state_d = S_VRD;
      end
      S_VRD: begin
        if (vrd_valid)    state_d = S_IDLE;
        else if (base_we) state_d = S_DRN_VRD;
      end
      S_DRN_RSP: if (rsp_valid) state_d = S_IDLE;
      S_DRN_VRD: if (vrd_valid) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE)                        idx_q <= '0;
      else if (buf_we && !last_dw && !base_we)      idx_q <= idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int SIZE_W     = 8,
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int OFF_W     = PG_W + SIZE_W,
  localparam int PKT_W     = PKT_DW * DW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [SIZE_W-1:0] base_pages,
  input  logic              wptr_we,
  input  logic [OFF_W-1:0]  wptr_wdata,
  output logic [OFF_W-1:0]  wptr,
  output logic [OFF_W-1:0]  rptr,
  output logic              stalled,
  output logic              mrd_req_valid,
  input  logic              mrd_req_ready,
  output logic [ADDR_W-1:0] mrd_req_addr,
  input  logic              mrd_rsp_valid,
  output logic              mrd_rsp_ready,
  input  logic [DW_W-1:0]   mrd_rsp_data,
  input  logic              mrd_rsp_err,
  output logic              dsp_valid,
  input  logic              dsp_ready,
  output logic [7:0]        dsp_opcode,
  output logic [PKT_W-1:0]  dsp_pkt,
  input  logic              vrd_valid,
  output logic              vrd_ready,
  input  logic              vrd_stall
);
  localparam int IDX_W = $clog2(PKT_DW);

  logic [ADDR_W-1:0] base_q;
  logic              adv;
  logic              stall_set;
  logic              buf_we;
  logic [IDX_W-1:0]  buf_idx;
  logic              seq_live;

  cmdq_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .PG_W(PG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_we    (base_we),
    .base_addr  (base_addr),
    .base_pages (base_pages),
    .wptr_we    (wptr_we),
    .wptr_wdata (wptr_wdata),
    .adv        (adv),
    .stall_set  (stall_set),
    .base_q     (base_q),
    .wptr_q     (wptr),
    .rptr_q     (rptr),
    .stalled_q  (stalled)
  );

  cmdq_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .base_we   (base_we),
    .base_q    (base_q),
    .rptr      (rptr),
    .wptr      (wptr),
    .stalled   (stalled),
    .req_valid (mrd_req_valid),
    .req_ready (mrd_req_ready),
    .req_addr  (mrd_req_addr),
    .rsp_valid (mrd_rsp_valid),
    .rsp_ready (mrd_rsp_ready),
    .rsp_err   (mrd_rsp_err),
    .buf_we    (buf_we),
    .buf_idx   (buf_idx),
    .dsp_valid (dsp_valid),
    .dsp_ready (dsp_ready),
    .vrd_valid (vrd_valid),
    .vrd_ready (vrd_ready),
    .vrd_stall (vrd_stall),
    .adv       (adv),
    .stall_set (stall_set),
    .live      (seq_live)
  );

  cmdq_pktbuf u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (buf_we),
    .wr_idx  (buf_idx),
    .wr_data (mrd_rsp_data),
    .pkt     (dsp_pkt)
  );

  assign dsp_opcode = dsp_pkt[7:0];
endmodule

// File: rtl/cmdq_engine_chk.sv
module cmdq_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 20,
  parameter int PKT_W  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              base_we,
  input logic              wptr_we,
  input logic [OFF_W-1:0]  wptr,
  input logic [OFF_W-1:0]  rptr,
  input logic              stalled,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_err,
  input logic              dsp_valid,
  input logic              dsp_ready,
  input logic [PKT_W-1:0]  dsp_pkt,
  input logic              vrd_valid,
  input logic              vrd_ready,
  input logic              vrd_stall,
  input logic              live
);
  p_fault_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rsp_valid && rsp_ready && rsp_err && !base_we) |=> stalled);

  p_fault_keeps_rptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rsp_valid && rsp_ready && rsp_err && !base_we) |=> $stable(rptr));

  p_adv_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && vrd_valid && vrd_ready && !vrd_stall && !base_we)
      |=> ((rptr == $past(rptr) + OFF_W'(32)) || (rptr == '0)));

  p_verdict_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && vrd_valid && vrd_ready && vrd_stall && !base_we) |=> stalled);

  p_stalled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> (!req_valid && !dsp_valid));

  p_base_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> (rptr == '0 && !stalled));

  p_base_keeps_wptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we && !wptr_we) |=> $stable(wptr));

  p_rptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_we && !(live && vrd_valid && vrd_ready && !vrd_stall)) |=> $stable(rptr));

  p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid || vrd_ready) |-> !req_valid);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !base_we) |=> (req_valid && $stable(req_addr)));

  p_dsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready && !base_we) |=> (dsp_valid && $stable(dsp_pkt)));

  p_wptr_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wptr[4:0] == 5'd0);
endmodule

bind cmdq_engine cmdq_engine_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .PKT_W(PKT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .base_we   (base_we),
  .wptr_we   (wptr_we),
  .wptr      (wptr),
  .rptr      (rptr),
  .stalled   (stalled),
  .req_valid (mrd_req_valid),
  .req_ready (mrd_req_ready),
  .req_addr  (mrd_req_addr),
  .rsp_valid (mrd_rsp_valid),
  .rsp_ready (mrd_rsp_ready),
  .rsp_err   (mrd_rsp_err),
  .dsp_valid (dsp_valid),
  .dsp_ready (dsp_ready),
  .dsp_pkt   (dsp_pkt),
  .vrd_valid (vrd_valid),
  .vrd_ready (vrd_ready),
  .vrd_stall (vrd_stall),
  .live      (seq_live)
);

// File: tb/cmdq_engine_test.sv
`timescale 1ns/1ps
module cmdq_engine_test;
  localparam int OFF_W = 8;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic base_we = 1'b0;
  logic [31:0] base_addr = '0;
  logic [1:0] base_pages = '0;
  logic wptr_we = 1'b0;
  logic [OFF_W-1:0] wptr_wdata = '0;
  logic [OFF_W-1:0] wptr, rptr;
  logic stalled;
  logic mrd_req_valid, mrd_rsp_ready, dsp_valid, vrd_ready;
  logic mrd_req_ready = 1'b1;
  logic [31:0] mrd_req_addr;
  logic mrd_rsp_valid = 1'b0;
  logic [63:0] mrd_rsp_data = '0;
  logic mrd_rsp_err = 1'b0;
  logic dsp_ready = 1'b0;
  logic [7:0] dsp_opcode;
  logic [255:0] dsp_pkt;
  logic vrd_valid = 1'b0;
  logic vrd_stall = 1'b0;

  always #2.5 clk = ~clk;

  cmdq_engine #(.ADDR_W(32), .PAGE_BYTES(64), .SIZE_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .base_we(base_we), .base_addr(base_addr), .base_pages(base_pages),
    .wptr_we(wptr_we), .wptr_wdata(wptr_wdata),
    .wptr(wptr), .rptr(rptr), .stalled(stalled),
    .mrd_req_valid(mrd_req_valid), .mrd_req_ready(mrd_req_ready), .mrd_req_addr(mrd_req_addr),
    .mrd_rsp_valid(mrd_rsp_valid), .mrd_rsp_ready(mrd_rsp_ready),
    .mrd_rsp_data(mrd_rsp_data), .mrd_rsp_err(mrd_rsp_err),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_opcode(dsp_opcode), .dsp_pkt(dsp_pkt),
    .vrd_valid(vrd_valid), .vrd_ready(vrd_ready), .vrd_stall(vrd_stall)
  );

  int n_chk = 0;
  int n_fail = 0;
  int req_cnt = 0;
  int disp_cnt = 0;
  bit cmd_busy = 1'b0;
  bit done = 1'b0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] exp_addr_q[$];
  logic [255:0] exp_pkt_q[$];
  bit verdict_q[$];

  function automatic logic [63:0] mdata(input logic [31:0] a);
    return {~a, a ^ 32'h5A5A_0000};
  endfunction

  function automatic logic [255:0] mpkt(input logic [31:0] a);
    return {mdata(a + 32'd24), mdata(a + 32'd16), mdata(a + 32'd8), mdata(a)};
  endfunction

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  // driver side of the scoreboard: expected reads, packet and verdict
  task automatic push_cmd(input logic [7:0] off, input bit stall_v);
    for (int k = 0; k < 4; k++) exp_addr_q.push_back(BASE + 32'(off) + 32'(8 * k));
    exp_pkt_q.push_back(mpkt(BASE + 32'(off)));
    verdict_q.push_back(stall_v);
  endtask

  task automatic push_reads(input logic [7:0] off, input int n);
    for (int k = 0; k < n; k++) exp_addr_q.push_back(BASE + 32'(off) + 32'(8 * k));
  endtask

  task automatic base_wr(input logic [31:0] a, input logic [1:0] p);
    base_addr = a; base_pages = p; base_we = 1'b1;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic wptr_wr(input logic [7:0] v);
    wptr_wdata = v; wptr_we = 1'b1;
    @(negedge clk);
    wptr_we = 1'b0;
  endtask

  task automatic wait_rptr(input logic [7:0] t);
    for (int n = 0; n < 400 && rptr !== t; n++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_stall();
    for (int n = 0; n < 400 && stalled !== 1'b1; n++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  // memory model and read monitor
  initial begin
    logic [31:0] a;
    logic [31:0] e;
    forever begin
      @(negedge clk);
      mrd_rsp_valid = 1'b0;
      mrd_rsp_err = 1'b0;
      if (rst_n && mrd_req_valid) begin
        a = mrd_req_addr;
        req_cnt++;
        chk(!cmd_busy, $sformatf("R9 read issued while a command awaits its verdict, addr %h", a));
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, $sformatf("R1 unexpected read: actual %h expected none", a));
        end else begin
          e = exp_addr_q.pop_front();
          chk(a == e, $sformatf("R1 read address: actual %h expected %h", a, e));
        end
        @(negedge clk);
        mrd_rsp_valid = 1'b1;
        mrd_rsp_data = mdata(a);
        mrd_rsp_err = (a == err_addr);
      end
    end
  end

  // handler model and dispatch monitor
  initial begin
    logic [255:0] snap;
    logic [255:0] e;
    int hdly;
    hdly = 1;
    forever begin
      @(negedge clk);
      if (rst_n && dsp_valid) begin
        snap = dsp_pkt;
        for (int k = 0; k < hdly; k++) begin
          @(negedge clk);
          chk(dsp_valid && dsp_pkt == snap,
              $sformatf("R10 dispatch not held: valid %b pkt %h expected %h", dsp_valid, dsp_pkt, snap));
        end
        hdly = (hdly + 1) % 3;
        dsp_ready = 1'b1;
        disp_cnt++;
        if (exp_pkt_q.size() == 0) begin
          chk(1'b0, $sformatf("R1 unexpected dispatch: actual %h expected none", dsp_pkt));
        end else begin
          e = exp_pkt_q.pop_front();
          chk(dsp_pkt == e, $sformatf("R1 packet: actual %h expected %h", dsp_pkt, e));
          chk(dsp_opcode == e[7:0], $sformatf("R1 opcode: actual %h expected %h", dsp_opcode, e[7:0]));
        end
        @(negedge clk);
        dsp_ready = 1'b0;
        cmd_busy = 1'b1;
        @(negedge clk);
        vrd_valid = 1'b1;
        vrd_stall = (verdict_q.size() != 0) ? verdict_q.pop_front() : 1'b0;
        @(negedge clk);
        vrd_valid = 1'b0;
        vrd_stall = 1'b0;
        cmd_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int rc;
    int dc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rptr == 0 && wptr == 0, $sformatf("R7 reset offsets: actual %h/%h expected 0/0", rptr, wptr));
    chk(!stalled && !mrd_req_valid && !dsp_valid,
        $sformatf("R8 reset quiet: actual stalled %b req %b dsp %b expected 0", stalled, mrd_req_valid, dsp_valid));

    // two continue commands
    base_wr(BASE, 2'd1);
    en = 1'b1;
    push_cmd(8'd0, 1'b0);
    push_cmd(8'd32, 1'b0);
    wptr_wr(8'd64);
    wait_rptr(8'd64);
    chk(rptr == 8'd64, $sformatf("R4 read offset after two continues: actual %h expected 40", rptr));

    // unaligned write offset
    rc = req_cnt;
    wptr_wr(8'h5F);
    repeat (10) @(negedge clk);
    chk(wptr == 8'h40, $sformatf("R11 write offset alignment: actual %h expected 40", wptr));
    chk(req_cnt == rc, $sformatf("R8 equal offsets start nothing: actual %0d reads expected %0d", req_cnt, rc));

    // wrap across the 128-byte queue end
    push_cmd(8'd64, 1'b0);
    push_cmd(8'd96, 1'b0);
    push_cmd(8'd0, 1'b0);
    wptr_wr(8'd32);
    wait_rptr(8'd32);
    chk(rptr == 8'd32, $sformatf("R6 wrap: actual %h expected 20", rptr));

    // disable with work pending, then resume
    en = 1'b0;
    rc = req_cnt;
    push_cmd(8'd32, 1'b0);
    wptr_wr(8'd64);
    repeat (20) @(negedge clk);
    chk(rptr == 8'd32 && req_cnt == rc,
        $sformatf("R8 disabled: actual rptr %h reads %0d expected 20 and %0d", rptr, req_cnt, rc));
    en = 1'b1;
    wait_rptr(8'd64);
    chk(rptr == 8'd64, $sformatf("R8 resume keeps offset: actual %h expected 40", rptr));

    // stall verdict
    push_cmd(8'd64, 1'b1);
    wptr_wr(8'd96);
    wait_stall();
    chk(stalled && rptr == 8'd64,
        $sformatf("R5 stall verdict: actual stalled %b rptr %h expected 1 and 40", stalled, rptr));
    rc = req_cnt;
    repeat (20) @(negedge clk);
    chk(req_cnt == rc, $sformatf("R5 no reads while stalled: actual %0d expected %0d", req_cnt, rc));

    // base write clears offset and stall, keeps write offset
    push_cmd(8'd0, 1'b0);
    push_cmd(8'd32, 1'b0);
    push_cmd(8'd64, 1'b0);
    base_wr(BASE, 2'd1);
    chk(rptr == 0 && !stalled && wptr == 8'd96,
        $sformatf("R7 base write: actual rptr %h stalled %b wptr %h expected 0 0 60", rptr, stalled, wptr));
    wait_rptr(8'd96);
    chk(rptr == 8'd96, $sformatf("R7 reprocess from zero: actual %h expected 60", rptr));

    // fault on the first doubleword
    err_addr = BASE + 32'd96;
    push_reads(8'd96, 1);
    dc = disp_cnt;
    rc = req_cnt;
    wptr_wr(8'd0);
    wait_stall();
    chk(stalled && rptr == 8'd96,
        $sformatf("R2 dw0 fault: actual stalled %b rptr %h expected 1 and 60", stalled, rptr));
    chk(disp_cnt == dc && req_cnt == rc + 1,
        $sformatf("R2 dw0 fault: actual %0d dispatches %0d reads expected %0d and %0d", disp_cnt, req_cnt, dc, rc + 1));

    // fault on the third doubleword
    base_wr(BASE, 2'd1);
    chk(rptr == 0 && !stalled && wptr == 0,
        $sformatf("R7 second base write: actual rptr %h stalled %b wptr %h expected 0 0 0", rptr, stalled, wptr));
    err_addr = BASE + 32'd16;
    push_reads(8'd0, 3);
    dc = disp_cnt;
    wptr_wr(8'd32);
    wait_stall();
    chk(stalled && rptr == 0 && disp_cnt == dc,
        $sformatf("R3 dw2 fault: actual stalled %b rptr %h dispatches %0d expected 1 0 %0d", stalled, rptr, disp_cnt, dc));
    chk(exp_addr_q.size() == 0, $sformatf("R3 reads after fault: actual %0d left expected 0", exp_addr_q.size()));

    // recover
    err_addr = 32'hFFFF_FFFF;
    push_cmd(8'd0, 1'b0);
    base_wr(BASE, 2'd1);
    wait_rptr(8'd32);
    chk(rptr == 8'd32 && !stalled,
        $sformatf("R4 recovery: actual rptr %h stalled %b expected 20 0", rptr, stalled));

    chk(exp_addr_q.size() == 0 && exp_pkt_q.size() == 0,
        $sformatf("R1 scoreboard drained: actual %0d reads %0d packets expected 0", exp_addr_q.size(), exp_pkt_q.size()));

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule